// File: doc/BRIEF.md
# I2C Master Interrupt Status Controller

This block gathers the interrupt sources of an I2C master controller. Single-cycle event pulses from the FIFOs and the bus engine set sticky bits in a raw status word. Two live levels sit in the same word: the receive FIFO at or above its threshold, and the transmit FIFO at or below its threshold. Software sees the raw word and also a masked word, which is the raw word gated by a writable mask. One interrupt line is the OR of the masked bits.

Software clears each sticky source by reading a dedicated clear address. This leaves every other pending source untouched, so an event that lands between a status read and its clear is never lost. One clear-all address wipes every sticky source at once. When a transmit abort fires, its cause is captured by OR-ing a reason vector into an abort-cause register. That register is emptied together with the abort flag.

A separate bus status word shows whether the master engine is active. Register accesses use a simple strobe-based read/write port, and read data is registered.

Top module: `i2cm_irq_ctrl`

## Requirements
- R1: After reset the sticky bits, the mask, the abort-cause register and the read data are all zero, and `irq_o` is low.
- R2: An `evt_i` pulse on a sticky position sets that bit, and the bit stays set until it is cleared. The sticky positions are: 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R3: Reading a per-source clear address clears only its own bit, and the read returns 0. The addresses are: 0x06 bit0, 0x07 bit1, 0x08 bit3, 0x09 bit5, 0x0A bit6, 0x0B bit7, 0x0C bit8, 0x0D bit9, 0x0E bit10, 0x0F bit11.
- R4: If a source's event arrives in the same cycle as a read of that source's clear address (or of the clear-all address), the event wins and the bit stays set.
- R5: A read of 0x05 clears all sticky bits and the abort-cause register, and returns 0.
- R6: Raw bit 2 follows `rx_full_i` and raw bit 4 follows `tx_empty_i` live. Neither has a clear address, and `evt_i` pulses at bits 2 and 4 have no effect.
- R7: Address 0x02 reads the raw word unmasked. Address 0x01 reads raw AND mask. Address 0x00 reads and writes the 12-bit mask. `irq_o` is the OR of the masked bits.
- R8: Writing a mask of zero forces `irq_o` low and leaves the raw word unchanged.
- R9: Each tx-abort event (bit 6) ORs `abort_reason_i` into the abort-cause register, read at 0x03. A read of 0x0A clears this register together with bit 6. If a new abort arrives in the clearing cycle, the register holds that event's reason alone.
- R10: Address 0x04 reads the bus status word, whose bit 5 is `master_act_i` (1 = active, 0 = idle); all other bits are 0.
- R11: Reads of addresses 0x10 to 0x1F return 0. Writes to any address other than 0x00 change nothing.
- R12: Read data appears on `rdata_o` one cycle after the `rd_i` strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 12 | Single-cycle event pulses, one per status position |
| rx_full_i | input | 1 | Receive FIFO at or above threshold (level) |
| tx_empty_i | input | 1 | Transmit FIFO at or below threshold (level) |
| abort_reason_i | input | ABRT_W | Cause bits sampled with a tx-abort event |
| master_act_i | input | 1 | Master engine not idle |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
- **Read data:** it is due on the clock edge that ends the `rd_i` cycle. Its value comes from the state in place before that edge.
- **Sticky bits and the abort-cause register:** clears and events take effect on that same edge.
- **`irq_o`:** it follows the new state and the live levels straight after the edge.

The bench drives every input at the falling edge and steps a bench-side model at the rising edge. It samples 1 ns after the rising edge, so each check reads exactly the cycle in which its result is due.

// File: rtl/i2cm_irq_pkg.sv
package i2cm_irq_pkg;

  localparam int STAT_W = 12;

  localparam int B_RX_FULL  = 2;
  localparam int B_TX_EMPTY = 4;
  localparam int B_TX_ABORT = 6;
  localparam int BUS_ACT_BIT = 5;

  localparam logic [STAT_W-1:0] LEVEL_BITS  = 12'h014;
  localparam logic [STAT_W-1:0] STICKY_BITS = ~LEVEL_BITS;

  localparam int A_MASK    = 0;
  localparam int A_MSTAT   = 1;
  localparam int A_RAW     = 2;
  localparam int A_ABORT   = 3;
  localparam int A_BUS     = 4;
  localparam int A_CLR_ALL = 5;
  localparam int A_CLR_LO  = 6;
  localparam int A_CLR_HI  = 15;

  // Per-source clear address for a sticky bit position.
  function automatic int clr_addr(input int b);
    if (b < B_RX_FULL)       return A_CLR_LO + b;
    else if (b < B_TX_EMPTY) return A_CLR_LO + b - 1;
    else                     return A_CLR_LO + b - 2;
  endfunction

endpackage

// File: rtl/i2cm_irq_sticky.sv
module i2cm_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;
  logic q_n;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_n  = set_i;            // a same-cycle event beats the clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_n;
  end

  assign q_o = q_q;

  // R4: event always leaves the bit set
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R3: clear without event drops the bit
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R2: no event and no clear keeps the bit
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/i2cm_irq_abort_cap.sv
module i2cm_irq_abort_cap #(
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic [ABRT_W-1:0] reason_i,
  input  logic              clr_i,
  output logic [ABRT_W-1:0] src_o
);

  logic [ABRT_W-1:0] src_q;
  logic [ABRT_W-1:0] src_n;
  logic              src_en;

  always_comb begin
    src_en = evt_i | clr_i;
    src_n  = clr_i ? '0 : src_q;
    if (evt_i) src_n = src_n | reason_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_en) src_q <= src_n;
  end

  assign src_o = src_q;

  // R9: clear without new abort empties the cause register
  a_r9_cause_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> (src_o == '0));
  // R9: an abort always leaves its reason bits present
  a_r9_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> ((src_o & $past(reason_i)) == $past(reason_i)));
  // R9: nothing changes the register when idle
  a_r9_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !clr_i) |=> $stable(src_o));

endmodule

// File: rtl/i2cm_irq_regif.sv
module i2cm_irq_regif
  import i2cm_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] raw_i,
  input  logic [ABRT_W-1:0] abort_i,
  input  logic              busy_i,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] clr_o,
  output logic              clr_all_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] mask_n;
  logic              mask_en;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_n;

  // per-source clear decode
  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_clr
      if (STICKY_BITS[gi]) begin : g_stk
        assign clr_o[gi] = rd_i && (addr_i == ADDR_W'(clr_addr(gi)));
      end else begin : g_lvl
        assign clr_o[gi] = 1'b0;
      end
    end
  endgenerate

  assign clr_all_o = rd_i && (addr_i == ADDR_W'(A_CLR_ALL));

  always_comb begin
    mask_en = wr_i && (addr_i == ADDR_W'(A_MASK));
    mask_n  = wdata_i[STAT_W-1:0];
  end

  always_comb begin
    rdata_n = '0;
    case (addr_i)
      ADDR_W'(A_MASK):  rdata_n[STAT_W-1:0] = mask_q;
      ADDR_W'(A_MSTAT): rdata_n[STAT_W-1:0] = raw_i & mask_q;
      ADDR_W'(A_RAW):   rdata_n[STAT_W-1:0] = raw_i;
      ADDR_W'(A_ABORT): rdata_n[ABRT_W-1:0] = abort_i;
      ADDR_W'(A_BUS):   rdata_n[BUS_ACT_BIT] = busy_i;
      default:          rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_i)  rdata_q <= rdata_n;
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  // R3: a clear read returns zero
  a_r3_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (clr_o != '0)) |=> (rdata_o == '0));
  // R11: writes elsewhere leave the mask alone
  a_r11_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (addr_i != ADDR_W'(A_MASK))) |=> $stable(mask_o));
  // R12: read data holds without a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
  // R3: at most one per-source clear per access
  a_r3_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));

endmodule

// File: rtl/i2cm_irq_ctrl.sv
module i2cm_irq_ctrl
  import i2cm_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int ABRT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       evt_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic [ABRT_W-1:0] abort_reason_i,
  input  logic              master_act_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic [STAT_W-1:0] raw;
  logic [STAT_W-1:0] mask;
  logic [STAT_W-1:0] clr;
  logic              clr_all;
  logic [ABRT_W-1:0] abort_src;

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_src
      if (gi == B_RX_FULL) begin : g_rxf
        assign raw[gi] = rx_full_i;
      end else if (gi == B_TX_EMPTY) begin : g_txe
        assign raw[gi] = tx_empty_i;
      end else begin : g_stk
        i2cm_irq_sticky u_bit (
          .clk   (clk),
          .rst_n (rst_n),
          .set_i (evt_i[gi]),
          .clr_i (clr[gi] | clr_all),
          .q_o   (raw[gi])
        );
      end
    end
  endgenerate

  i2cm_irq_abort_cap #(.ABRT_W(ABRT_W)) u_abort (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i[B_TX_ABORT]),
    .reason_i (abort_reason_i),
    .clr_i    (clr[B_TX_ABORT] | clr_all),
    .src_o    (abort_src)
  );

  i2cm_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ABRT_W(ABRT_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .raw_i     (raw),
    .abort_i   (abort_src),
    .busy_i    (master_act_i),
    .mask_o    (mask),
    .clr_o     (clr),
    .clr_all_o (clr_all),
    .rdata_o   (rdata_o)
  );

  assign irq_o = |(raw & mask);

  // R8: zero mask keeps the line quiet
  a_r8_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
  // R5: clear-all with no incoming event empties every sticky bit and the cause
  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && ((evt_i & STICKY_BITS) == '0)) |=>
      (((raw & STICKY_BITS) == '0) && (abort_src == '0)));
  // R6: level bits track their inputs
  a_r6_levels_live: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[B_RX_FULL] == rx_full_i) && (raw[B_TX_EMPTY] == tx_empty_i));

endmodule

// File: tb/i2cm_irq_ctrl_tb_top.sv
module i2cm_irq_ctrl_tb_top;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int ABRT_W = 16;
  localparam logic [11:0] STK = 12'hFEB;

  logic              clk;
  logic              rst_n;
  logic [11:0]       evt;
  logic              rxf;
  logic              txe;
  logic [ABRT_W-1:0] reason;
  logic              act;
  logic              rd;
  logic              wr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int unsigned total = 0;
  int unsigned bad   = 0;
  bit          done  = 0;
  string       tag;

  logic [11:0]       m_stk;
  logic [11:0]       m_mask;
  logic [ABRT_W-1:0] m_abrt;
  logic [DATA_W-1:0] m_rdata;

  i2cm_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ABRT_W(ABRT_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt),
    .rx_full_i      (rxf),
    .tx_empty_i     (txe),
    .abort_reason_i (reason),
    .master_act_i   (act),
    .rd_i           (rd),
    .wr_i           (wr),
    .addr_i         (addr),
    .wdata_i        (wdata),
    .rdata_o        (rdata),
    .irq_o          (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [11:0] m_raw();
    logic [11:0] r;
    r = m_stk;
    r[2] = rxf;
    r[4] = txe;
    return r;
  endfunction

  // R3 clear address table
  function automatic logic [11:0] clr_of(input logic [ADDR_W-1:0] a);
    case (a)
      5'h06: return 12'h001;
      5'h07: return 12'h002;
      5'h08: return 12'h008;
      5'h09: return 12'h020;
      5'h0A: return 12'h040;
      5'h0B: return 12'h080;
      5'h0C: return 12'h100;
      5'h0D: return 12'h200;
      5'h0E: return 12'h400;
      5'h0F: return 12'h800;
      5'h05: return STK;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
    case (a)
      5'h00: return {20'h0, m_mask};
      5'h01: return {20'h0, m_raw() & m_mask};
      5'h02: return {20'h0, m_raw()};
      5'h03: return {16'h0, m_abrt};
      5'h04: return {26'h0, act, 5'h0};
      default: return 32'h0;
    endcase
  endfunction

  // Called at a falling edge with inputs set; ends at the next falling edge.
  task automatic cycle();
    logic [31:0]       er;
    logic [11:0]       cm;
    logic [11:0]       nx;
    logic [ABRT_W-1:0] na;
    logic [11:0]       nm;
    er = exp_read(addr);
    cm = rd ? clr_of(addr) : 12'h000;
    nx = (m_stk & ~cm) | (evt & STK);
    na = cm[6] ? '0 : m_abrt;
    if (evt[6]) na = na | reason;
    nm = (wr && addr == 5'h00) ? wdata[11:0] : m_mask;
    @(posedge clk);
    #1;
    m_stk = nx;
    m_abrt = na;
    m_mask = nm;
    if (rd) m_rdata = er;
    check({tag, " R12 rdata"}, rdata, m_rdata);
    check({tag, " R7 irq"}, {31'h0, irq}, {31'h0, |(m_raw() & m_mask)});
    @(negedge clk);
    evt = '0; rd = 0; wr = 0; reason = '0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    rd = 1; addr = a;
    cycle();
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    cycle();
  endtask

  task automatic pulse(input logic [11:0] e, input logic [ABRT_W-1:0] r);
    evt = e; reason = r;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; evt = '0; rxf = 0; txe = 0; reason = '0; act = 0;
    rd = 0; wr = 0; addr = '0; wdata = '0;
    m_stk = '0; m_mask = '0; m_abrt = '0; m_rdata = '0;
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    do_read(5'h02); check("R1 raw zero", rdata, 32'h0);
    do_read(5'h00); check("R1 mask zero", rdata, 32'h0);
    do_read(5'h03); check("R1 abort zero", rdata, 32'h0);

    tag = "R2";
    pulse(12'h200, '0);
    do_read(5'h02); check("R2 stop bit set", rdata, 32'h200);
    repeat (3) cycle();
    do_read(5'h02); check("R2 stop bit held", rdata, 32'h200);

    tag = "R3";
    do_read(5'h0D); check("R3 clear returns zero", rdata, 32'h0);
    do_read(5'h02); check("R3 stop cleared", rdata, 32'h0);
    pulse(12'h003, '0);
    do_read(5'h06);
    do_read(5'h02); check("R3 only bit0 cleared", rdata, 32'h002);
    do_read(5'h07);

    tag = "R4";
    pulse(12'h200, '0);
    evt = 12'h200; rd = 1; addr = 5'h0D; cycle();
    do_read(5'h02); check("R4 event beats clear", rdata, 32'h200);
    evt = 12'h100; rd = 1; addr = 5'h05; cycle();
    do_read(5'h02); check("R4 event beats clear-all", rdata, 32'h100);

    tag = "R5";
    pulse(12'hFEB, 16'h00A5);
    do_read(5'h05); check("R5 clear-all returns zero", rdata, 32'h0);
    do_read(5'h02); check("R5 all sticky cleared", rdata, 32'h0);
    do_read(5'h03); check("R5 abort cause cleared", rdata, 32'h0);

    tag = "R6";
    rxf = 1; do_read(5'h02); check("R6 rx full live", rdata, 32'h004);
    rxf = 0; txe = 1; do_read(5'h02); check("R6 tx empty live", rdata, 32'h010);
    txe = 0; pulse(12'h014, '0);
    do_read(5'h02); check("R6 level event ignored", rdata, 32'h0);

    tag = "R7";
    pulse(12'h401, '0);
    do_write(5'h00, 32'hFFFF_0400);
    do_read(5'h00); check("R7 mask readback", rdata, 32'h400);
    do_read(5'h01); check("R7 masked status", rdata, 32'h400);
    check("R7 irq high", {31'h0, irq}, 32'h1);

    tag = "R8";
    do_write(5'h00, 32'h0);
    check("R8 irq low with zero mask", {31'h0, irq}, 32'h0);
    do_read(5'h02); check("R8 raw unchanged", rdata, 32'h401);
    do_read(5'h05);

    tag = "R9";
    pulse(12'h040, 16'h0011);
    pulse(12'h040, 16'h0100);
    do_read(5'h03); check("R9 causes accumulate", rdata, 32'h0111);
    evt = 12'h040; reason = 16'h8000; rd = 1; addr = 5'h0A; cycle();
    do_read(5'h03); check("R9 new abort in clear cycle", rdata, 32'h8000);
    do_read(5'h0A);
    do_read(5'h03); check("R9 abort clear empties cause", rdata, 32'h0);
    do_read(5'h02); check("R9 abort flag cleared", rdata, 32'h0);

    tag = "R10";
    act = 1; do_read(5'h04); check("R10 master active", rdata, 32'h20);
    act = 0; do_read(5'h04); check("R10 master idle", rdata, 32'h0);

    tag = "R11";
    do_write(5'h00, 32'h0F0);
    do_write(5'h02, 32'hFFFF_FFFF);
    do_read(5'h00); check("R11 write elsewhere ignored", rdata, 32'h0F0);
    act = 1; do_read(5'h14); check("R11 unused reads zero", rdata, 32'h0);
    act = 0;

    tag = "R12 random";
    for (int i = 0; i < 4000; i++) begin
      evt    = 12'($urandom & $urandom & $urandom);
      reason = 16'($urandom);
      if ($urandom % 8 == 0) rxf = 1'($urandom);
      if ($urandom % 8 == 0) txe = 1'($urandom);
      act    = 1'($urandom);
      rd     = 1'($urandom);
      wr     = ($urandom % 8 == 0);
      addr   = 5'($urandom % 24);
      wdata  = $urandom;
      cycle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule